// File: doc/BRIEF.md
# ADC Analog Watchdog Window Comparator

This block sits beside an ADC sequencer and inspects each conversion result in the cycle its valid strobe is high. Each result arrives with three attributes: a 12-bit right-aligned value, the number of the channel that produced it, and a bit that marks it as coming from the inserted group rather than the regular group. The block first decides whether the result is monitored. It then compares the value against a programmed low and high threshold. A value outside that window raises a sticky alarm flag. The flag stays up until software clears it. An interrupt output follows the flag, gated by an interrupt enable.

Filtering is set on configuration ports. Separate enables select regular results, inserted results, or both. Single-channel mode narrows the check to one selected channel and monitors both groups, whatever the group enables say. To turn the watchdog off, clear both group enables and single-channel mode; in that state no result can raise the flag.

The alarm is held in a two-state machine:
- `WD_WATCH` means the flag is clear. A monitored out-of-window result takes the transition "trip" to `WD_ALARM`.
- `WD_ALARM` means the flag is set. A clear pulse with no new hit in the same cycle takes the transition "acknowledge" back to `WD_WATCH`.
- In either state, any other input combination holds the state.

Top module: `adc_window_watch`

## Requirements
- R1: After reset, `wd_flag` and `wd_irq` are both 0.
- R2: A monitored result whose value is strictly greater than `cfg_high_thr` sets `wd_flag` at the clock edge on which it is presented.
- R3: A monitored result strictly below `cfg_low_thr` sets `wd_flag`. A value equal to either threshold, or between them, does not set it.
- R4: Outside single-channel mode, a result with `res_inserted`=0 (regular group) is checked only when `cfg_reg_en`=1. A result with `res_inserted`=1 (inserted group) is checked only when `cfg_ins_en`=1.
- R5: With `cfg_single_en`=1, only results whose `res_chan` equals `cfg_sel_chan` are checked. Such results are checked from both groups, even with both group enables at 0.
- R6: With `cfg_single_en`, `cfg_reg_en` and `cfg_ins_en` all 0 (watchdog off), no result sets `wd_flag`.
- R7: `wd_flag` stays set until `flag_clr` is high at a clock edge; it reads 0 after that edge.
- R8: If a monitored out-of-window result and `flag_clr` occur at the same edge, `wd_flag` remains set.
- R9: `wd_irq` is 1 exactly when `wd_flag` is 1 and `irq_en` is 1.
- R10: While `res_valid` is 0, the value and channel inputs have no effect on `wd_flag`.
- R11: With `cfg_low_thr`=0 and `cfg_high_thr`=4095, no 12-bit value sets `wd_flag`. With `cfg_low_thr`=`cfg_high_thr`=4095, the value 4094 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result valid strobe |
| res_data | input | 12 | Right-aligned conversion value |
| res_chan | input | 5 | Channel that produced the result |
| res_inserted | input | 1 | 1 = inserted group result, 0 = regular group result |
| cfg_low_thr | input | 12 | Low window threshold |
| cfg_high_thr | input | 12 | High window threshold |
| cfg_single_en | input | 1 | Monitor only the selected channel, both groups |
| cfg_sel_chan | input | 5 | Channel monitored in single-channel mode |
| cfg_reg_en | input | 1 | Monitor regular group results |
| cfg_ins_en | input | 1 | Monitor inserted group results |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear pulse for the alarm flag |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | Flag qualified by the interrupt enable |

## Verification
The assertions assume three things about the inputs. Configuration ports are quasi-static: they do not change in a cycle that carries a valid result. `flag_clr` is a one-cycle pulse. Values are already right-aligned 12-bit codes. The stimulus follows these rules:
- It changes configuration only in cycles where `res_valid` is low.
- It drives every strobe and clear for exactly one cycle, on the falling edge.
- It samples the flag on the following falling edge.

// File: rtl/adc_wd_pkg.sv
package adc_wd_pkg;

    typedef enum logic {
        WD_WATCH = 1'b0,
        WD_ALARM = 1'b1
    } wd_state_e;

endpackage

// File: rtl/wd_source_filter.sv
module wd_source_filter #(
    parameter int CHAN_W = 5
) (
    input  logic              res_valid,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic              res_inserted,
    input  logic              cfg_single_en,
    input  logic [CHAN_W-1:0] cfg_sel_chan,
    input  logic              cfg_reg_en,
    input  logic              cfg_ins_en,
    output logic              take
);

    logic group_ok;
    logic chan_ok;

    // Single-channel mode watches both groups regardless of group enables.
    always_comb begin
        if (cfg_single_en) begin
            group_ok = 1'b1;
        end else if (res_inserted) begin
            group_ok = cfg_ins_en;
        end else begin
            group_ok = cfg_reg_en;
        end
        chan_ok = !cfg_single_en || (res_chan == cfg_sel_chan);
        take    = res_valid && group_ok && chan_ok;
    end

endmodule

// File: rtl/wd_window_cmp.sv
module wd_window_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] low_thr,
    input  logic [DATA_W-1:0] high_thr,
    output logic              outside
);

    logic above;
    logic below;

    // Strict comparisons: values equal to a threshold are inside the window.
    always_comb begin
        above   = value > high_thr;
        below   = value < low_thr;
        outside = above || below;
    end

endmodule

// File: rtl/wd_event_fsm.sv
module wd_event_fsm
    import adc_wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic irq_en,
    output logic wd_flag,
    output logic wd_irq
);

    wd_state_e state_q;
    wd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_WATCH: if (hit) state_d = WD_ALARM;               // trip
            WD_ALARM: if (flag_clr && !hit) state_d = WD_WATCH;  // acknowledge
            default:  state_d = WD_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        wd_flag = (state_q == WD_ALARM);
        wd_irq  = wd_flag && irq_en;
    end

    // R7: the flag holds while no clear arrives
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag && !flag_clr |=> wd_flag);

    // R8: a hit together with a clear keeps the flag set
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit && flag_clr |=> wd_flag);

    // R2: the flag only rises after a hit
    assert_rise_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(hit));

endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic              res_inserted,
    input  logic [DATA_W-1:0] cfg_low_thr,
    input  logic [DATA_W-1:0] cfg_high_thr,
    input  logic              cfg_single_en,
    input  logic [CHAN_W-1:0] cfg_sel_chan,
    input  logic              cfg_reg_en,
    input  logic              cfg_ins_en,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              wd_flag,
    output logic              wd_irq
);

    logic take;
    logic outside;
    logic hit;

    wd_source_filter #(.CHAN_W(CHAN_W)) filter_i (
        .res_valid    (res_valid),
        .res_chan     (res_chan),
        .res_inserted (res_inserted),
        .cfg_single_en(cfg_single_en),
        .cfg_sel_chan (cfg_sel_chan),
        .cfg_reg_en   (cfg_reg_en),
        .cfg_ins_en   (cfg_ins_en),
        .take         (take)
    );

    wd_window_cmp #(.DATA_W(DATA_W)) cmp_i (
        .value   (res_data),
        .low_thr (cfg_low_thr),
        .high_thr(cfg_high_thr),
        .outside (outside)
    );

    assign hit = take && outside;

    wd_event_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .flag_clr(flag_clr),
        .irq_en  (irq_en),
        .wd_flag (wd_flag),
        .wd_irq  (wd_irq)
    );

    // R5: in single-channel mode a hit comes from the selected channel
    assert_single_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && cfg_single_en |-> res_chan == cfg_sel_chan);

    // R4: a regular-group hit outside single-channel mode needs the regular enable
    assert_reg_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !cfg_single_en && !res_inserted |-> cfg_reg_en);

    // R3: a hit always carries a value outside the window
    assert_hit_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (res_data > cfg_high_thr) || (res_data < cfg_low_thr));

    // R6: with the watchdog off nothing is ever checked
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_single_en && !cfg_reg_en && !cfg_ins_en |-> !hit);

endmodule

// File: tb/adc_window_watch_tb_top.sv
module adc_window_watch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic        res_inserted = 1'b0;
    logic [11:0] cfg_low_thr = 12'd100;
    logic [11:0] cfg_high_thr = 12'd3000;
    logic        cfg_single_en = 1'b0;
    logic [4:0]  cfg_sel_chan = '0;
    logic        cfg_reg_en = 1'b1;
    logic        cfg_ins_en = 1'b1;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        wd_flag;
    logic        wd_irq;

    int n_checks = 0;
    int n_fails = 0;

    always #5 clk = ~clk;

    adc_window_watch dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_inserted(res_inserted),
        .cfg_low_thr(cfg_low_thr), .cfg_high_thr(cfg_high_thr),
        .cfg_single_en(cfg_single_en), .cfg_sel_chan(cfg_sel_chan),
        .cfg_reg_en(cfg_reg_en), .cfg_ins_en(cfg_ins_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .wd_flag(wd_flag), .wd_irq(wd_irq)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic send(input logic [11:0] v, input logic [4:0] ch, input logic ins);
        @(negedge clk);
        res_valid = 1'b1; res_data = v; res_chan = ch; res_inserted = ins;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic default_cfg();
        cfg_low_thr = 12'd100; cfg_high_thr = 12'd3000;
        cfg_single_en = 1'b0; cfg_sel_chan = '0;
        cfg_reg_en = 1'b1; cfg_ins_en = 1'b1; irq_en = 1'b0;
        clear_flag();
    endtask

    task automatic t_reset();
        check(wd_flag, 1'b0, "R1 flag after reset");
        check(wd_irq, 1'b0, "R1 irq after reset");
    endtask

    task automatic t_high();
        default_cfg();
        send(12'd3000, 5'd1, 1'b0);
        check(wd_flag, 1'b0, "R3 equal high threshold");
        send(12'd3001, 5'd1, 1'b0);
        check(wd_flag, 1'b1, "R2 above high threshold");
    endtask

    task automatic t_low();
        default_cfg();
        send(12'd100, 5'd2, 1'b0);
        check(wd_flag, 1'b0, "R3 equal low threshold");
        send(12'd1500, 5'd2, 1'b1);
        check(wd_flag, 1'b0, "R3 inside window");
        send(12'd99, 5'd2, 1'b0);
        check(wd_flag, 1'b1, "R3 below low threshold");
    endtask

    task automatic t_groups();
        default_cfg();
        cfg_ins_en = 1'b0;
        send(12'd4000, 5'd3, 1'b1);
        check(wd_flag, 1'b0, "R4 inserted ignored when disabled");
        send(12'd4000, 5'd3, 1'b0);
        check(wd_flag, 1'b1, "R4 regular checked");
        default_cfg();
        cfg_reg_en = 1'b0;
        send(12'd5, 5'd3, 1'b0);
        check(wd_flag, 1'b0, "R4 regular ignored when disabled");
        send(12'd5, 5'd3, 1'b1);
        check(wd_flag, 1'b1, "R4 inserted checked");
    endtask

    task automatic t_single();
        default_cfg();
        cfg_single_en = 1'b1; cfg_sel_chan = 5'd17;
        cfg_reg_en = 1'b0; cfg_ins_en = 1'b0;
        send(12'd4000, 5'd16, 1'b0);
        check(wd_flag, 1'b0, "R5 other channel ignored");
        send(12'd4000, 5'd17, 1'b1);
        check(wd_flag, 1'b1, "R5 selected inserted channel checked");
        clear_flag();
        send(12'd0, 5'd17, 1'b0);
        check(wd_flag, 1'b1, "R5 selected regular channel checked");
    endtask

    task automatic t_off();
        default_cfg();
        cfg_reg_en = 1'b0; cfg_ins_en = 1'b0;
        send(12'd4095, 5'd0, 1'b0);
        send(12'd0, 5'd0, 1'b1);
        check(wd_flag, 1'b0, "R6 watchdog off");
    endtask

    task automatic t_sticky();
        default_cfg();
        send(12'd3500, 5'd4, 1'b0);
        send(12'd1000, 5'd4, 1'b0);
        repeat (3) @(negedge clk);
        check(wd_flag, 1'b1, "R7 flag sticky");
        clear_flag();
        check(wd_flag, 1'b0, "R7 flag cleared");
    endtask

    task automatic t_set_wins();
        default_cfg();
        send(12'd3500, 5'd4, 1'b0);
        @(negedge clk);
        res_valid = 1'b1; res_data = 12'd3600; res_chan = 5'd4; flag_clr = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; flag_clr = 1'b0;
        check(wd_flag, 1'b1, "R8 set wins over clear");
    endtask

    task automatic t_irq();
        default_cfg();
        irq_en = 1'b1;
        @(negedge clk);
        check(wd_irq, 1'b0, "R9 irq low without flag");
        send(12'd3500, 5'd4, 1'b0);
        check(wd_irq, 1'b1, "R9 irq with flag and enable");
        irq_en = 1'b0;
        #1;
        check(wd_irq, 1'b0, "R9 irq masked");
    endtask

    task automatic t_valid_low();
        default_cfg();
        @(negedge clk);
        res_data = 12'd4095; res_chan = 5'd1;
        @(negedge clk);
        res_data = 12'd0;
        @(negedge clk);
        check(wd_flag, 1'b0, "R10 invalid data ignored");
    endtask

    task automatic t_extremes();
        default_cfg();
        cfg_low_thr = 12'd0; cfg_high_thr = 12'd4095;
        send(12'd0, 5'd1, 1'b0);
        send(12'd4095, 5'd1, 1'b1);
        check(wd_flag, 1'b0, "R11 full window never trips");
        cfg_low_thr = 12'd4095;
        send(12'd4094, 5'd1, 1'b0);
        check(wd_flag, 1'b1, "R11 one below top low threshold");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_high();
        t_low();
        t_groups();
        t_single();
        t_off();
        t_sticky();
        t_set_wins();
        t_irq();
        t_valid_low();
        t_extremes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule